// File: doc/BRIEF.md
# Two-Core Line Coherence Tracker

This block keeps the coherence state of a single cache line that two cores may hold. Each core keeps its own copy in one of three states: Invalid, Shared or Modified. The block stores the pair of states as one joint register. The policy is write-invalidate: when one core writes, the other core's copy is dropped instead of updated. For every accepted request the block reports whether the request was a hit, where the data comes from, whether the other copy was invalidated, and whether dirty data had to be written back.

Each core has a valid/ready request channel. A request is one bit that selects read or write. A core raises valid and holds it, with the write bit unchanged, until a cycle in which ready is high. The transfer takes place on the rising edge where valid and ready are both high. Core 0 always has priority. When core 0 is valid, the ready of core 1 is low. Core 1 then keeps its request and is served in a later cycle, against the state that core 0's access leaves. Both readies are low while reset is asserted.

The response side is plain status with no back-pressure. It is valid for exactly one cycle, in the cycle after the request is accepted. The two state outputs always show the current joint state.

Top module: `msi_pair_tracker`

## Requirements
- R1: A synchronous active-high reset sets both line states to Invalid (00), clears resp_valid, and holds both readies low while it is asserted.
- R2: The state of each copy uses the codes Invalid=00, Shared=01 and Modified=10. The joint state is always one of I/I, S/I, I/S, S/S, M/I or I/M. The code 11 never appears, and a Modified copy never exists alongside another valid copy.
- R3: A read by a core whose copy is Invalid, while the other copy is also Invalid, is a miss with source memory (01). The requester becomes Shared, and there is no invalidation and no write-back.
- R4: A read by a core whose copy is Invalid, while the other copy is Modified, is a miss with source peer cache (10). Write-back is asserted, invalidation is not, and both copies become Shared.
- R5: A read by a core whose copy is Invalid, while the other copy is Shared, is a miss with source peer cache (10). There is no write-back and no invalidation, and both copies become Shared.
- R6: A read by a core whose copy is Shared or Modified is a hit with source local (00). Neither state changes, and there is no invalidation and no write-back.
- R7: A write by a core whose copy is Shared or Modified is a hit with source local (00). The requester becomes Modified and the other copy becomes Invalid. Invalidation is asserted exactly when the other copy was Shared.
- R8: A write by a core whose copy is Invalid is a miss. The requester becomes Modified and the other copy becomes Invalid. The source is memory (01) if the other copy was Invalid, and peer cache (10) otherwise. Invalidation is asserted when the other copy was valid. Write-back is asserted when the other copy was Modified.
- R9: When both cores are valid in the same cycle, only core 0 is accepted and core 1 sees ready low. The held core 1 request is answered in the next cycle, using the state that core 0's access produced.
- R10: An accepted request gives resp_valid high for exactly the next cycle, with resp_core naming the requester (0 or 1). In a cycle with no accepted request, resp_valid is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| c0_valid | input | 1 | Core 0 request valid |
| c0_write | input | 1 | Core 0 request is a write (1) or a read (0) |
| c0_ready | output | 1 | Core 0 request accepted this cycle if valid |
| c1_valid | input | 1 | Core 1 request valid |
| c1_write | input | 1 | Core 1 request is a write (1) or a read (0) |
| c1_ready | output | 1 | Core 1 request accepted this cycle if valid |
| resp_valid | output | 1 | Response present (one cycle per accepted request) |
| resp_core | output | 1 | Core that made the answered request |
| resp_hit | output | 1 | Request hit in the requester's own copy |
| resp_src | output | 2 | Data source: 00 local, 01 memory, 10 peer cache |
| resp_inval | output | 1 | The other core's valid copy was invalidated |
| resp_wb | output | 1 | The other core's dirty copy was written back |
| state0 | output | 2 | Current state of core 0's copy |
| state1 | output | 2 | Current state of core 1's copy |

## Verification
The bench targets the three miss cases that differ only in the peer's state. A design that mixed them up would take data from memory when the peer holds a dirty copy, or would flag a write-back for a clean peer. Writes to a Shared copy are also checked. Here a wrong design would miss the invalidation and leave a stale Shared copy next to a Modified one, which is the one joint state the block must never reach. Simultaneous requests are covered too: if core 1 were evaluated against the old state, it would report a hit on a copy that core 0 has just invalidated.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    SRC_LOCAL = 2'b00,
    SRC_MEM   = 2'b01,
    SRC_PEER  = 2'b10
  } src_e;

  // Result of one access: new requester state, new other state, response
  typedef struct packed {
    line_st_e req_nx;
    line_st_e oth_nx;
    logic     hit;
    src_e     src;
    logic     inval;
    logic     wb;
  } step_t;
endpackage

// File: rtl/msi_arbiter.sv
module msi_arbiter #(
  parameter int N_PORTS = 2
) (
  input  logic               rst,
  input  logic [N_PORTS-1:0] req,
  output logic [N_PORTS-1:0] rdy,
  output logic [N_PORTS-1:0] gnt
);
  // Fixed priority: the lowest index wins.
  generate
    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
      if (i == 0) begin : g_top
        assign rdy[i] = !rst;
      end else begin : g_low
        assign rdy[i] = !rst && !(|req[i-1:0]);
      end
      assign gnt[i] = req[i] && rdy[i];
    end
  endgenerate

  always_comb begin
    assert ($onehot0(gnt)) else $error("assert_onehot_grant_R9");
  end
endmodule

// File: rtl/msi_step.sv
module msi_step
  import msi_pkg::*;
(
  input  line_st_e req_st,
  input  line_st_e oth_st,
  input  logic     is_wr,
  output step_t    nx
);
  always_comb begin
    nx.req_nx = req_st;
    nx.oth_nx = oth_st;
    nx.hit    = (req_st != LN_INV);
    nx.src    = SRC_LOCAL;
    nx.inval  = 1'b0;
    nx.wb     = 1'b0;
    if (!is_wr) begin
      if (req_st == LN_INV) begin
        nx.req_nx = LN_SHR;
        case (oth_st)
          LN_MOD: begin
            nx.src    = SRC_PEER;
            nx.wb     = 1'b1;
            nx.oth_nx = LN_SHR;
          end
          LN_SHR:  nx.src = SRC_PEER;
          default: nx.src = SRC_MEM;
        endcase
      end
    end else begin
      nx.req_nx = LN_MOD;
      nx.oth_nx = LN_INV;
      nx.inval  = (oth_st != LN_INV);
      if (req_st == LN_INV) begin
        nx.src = (oth_st == LN_INV) ? SRC_MEM : SRC_PEER;
        nx.wb  = (oth_st == LN_MOD);
      end
    end
  end
endmodule

// File: rtl/msi_line_regs.sv
module msi_line_regs
  import msi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     take,
  input  logic     who,
  input  logic     is_wr,
  output line_st_e st0,
  output line_st_e st1,
  output logic     rv,
  output logic     rcore,
  output logic     rhit,
  output src_e     rsrc,
  output logic     rinval,
  output logic     rwb
);
  line_st_e req_st, oth_st;
  step_t    nx;
  logic     rwr;

  assign req_st = who ? st1 : st0;
  assign oth_st = who ? st0 : st1;

  msi_step u_step (
    .req_st(req_st),
    .oth_st(oth_st),
    .is_wr (is_wr),
    .nx    (nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st0    <= LN_INV;
      st1    <= LN_INV;
      rv     <= 1'b0;
      rcore  <= 1'b0;
      rhit   <= 1'b0;
      rsrc   <= SRC_LOCAL;
      rinval <= 1'b0;
      rwb    <= 1'b0;
      rwr    <= 1'b0;
    end else begin
      rv <= take;
      if (take) begin
        if (who) begin
          st1 <= nx.req_nx;
          st0 <= nx.oth_nx;
        end else begin
          st0 <= nx.req_nx;
          st1 <= nx.oth_nx;
        end
        rcore  <= who;
        rhit   <= nx.hit;
        rsrc   <= nx.src;
        rinval <= nx.inval;
        rwb    <= nx.wb;
        rwr    <= is_wr;
      end
    end
  end

  assert_legal_joint_R2: assert property (@(posedge clk) disable iff (rst)
    (st0 != 2'b11) && (st1 != 2'b11) &&
    !(st0 == LN_MOD && st1 != LN_INV) && !(st1 == LN_MOD && st0 != LN_INV));

  assert_wb_from_dirty_R4: assert property (@(posedge clk) disable iff (rst)
    rv && rwb |-> ((rcore ? $past(st0) : $past(st1)) == LN_MOD));

  assert_read_hit_stable_R6: assert property (@(posedge clk) disable iff (rst)
    rv && rhit && !rwr |-> (st0 == $past(st0)) && (st1 == $past(st1)));

  assert_writer_owns_R7: assert property (@(posedge clk) disable iff (rst)
    rv && rwr |-> ((rcore ? st1 : st0) == LN_MOD) && ((rcore ? st0 : st1) == LN_INV));
endmodule

// File: rtl/msi_pair_tracker.sv
module msi_pair_tracker
  import msi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       c0_valid,
  input  logic       c0_write,
  output logic       c0_ready,
  input  logic       c1_valid,
  input  logic       c1_write,
  output logic       c1_ready,
  output logic       resp_valid,
  output logic       resp_core,
  output logic       resp_hit,
  output logic [1:0] resp_src,
  output logic       resp_inval,
  output logic       resp_wb,
  output logic [1:0] state0,
  output logic [1:0] state1
);
  localparam int N_CORES = 2;

  logic [N_CORES-1:0] req, rdy, gnt;
  logic     take, who, is_wr;
  line_st_e st0, st1;
  src_e     rsrc;

  assign req = {c1_valid, c0_valid};

  msi_arbiter #(.N_PORTS(N_CORES)) u_arb (
    .rst(rst),
    .req(req),
    .rdy(rdy),
    .gnt(gnt)
  );

  assign c0_ready = rdy[0];
  assign c1_ready = rdy[1];
  assign take  = |gnt;
  assign who   = gnt[1];
  assign is_wr = gnt[1] ? c1_write : c0_write;

  msi_line_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .who   (who),
    .is_wr (is_wr),
    .st0   (st0),
    .st1   (st1),
    .rv    (resp_valid),
    .rcore (resp_core),
    .rhit  (resp_hit),
    .rsrc  (rsrc),
    .rinval(resp_inval),
    .rwb   (resp_wb)
  );

  assign resp_src = rsrc;
  assign state0   = st0;
  assign state1   = st1;

  assert_core0_first_R9: assert property (@(posedge clk) disable iff (rst)
    c0_valid && c1_valid |=> resp_valid && !resp_core);

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (c0_valid && c0_ready) || (c1_valid && c1_ready) |=> resp_valid);

  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (rst)
    !c0_valid && !c1_valid |=> !resp_valid);
endmodule

// File: tb/tb_msi_pair_tracker.sv
`timescale 1ns/1ps
module tb_msi_pair_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c0_valid = 1'b0, c0_write = 1'b0, c1_valid = 1'b0, c1_write = 1'b0;
  logic c0_ready, c1_ready, resp_valid, resp_core, resp_hit, resp_inval, resp_wb;
  logic [1:0] resp_src, state0, state1;

  int checks = 0;
  int fails  = 0;
  logic [1:0] m0, m1;

  always #10 clk = ~clk;

  msi_pair_tracker dut (
    .clk(clk), .rst(rst),
    .c0_valid(c0_valid), .c0_write(c0_write), .c0_ready(c0_ready),
    .c1_valid(c1_valid), .c1_write(c1_write), .c1_ready(c1_ready),
    .resp_valid(resp_valid), .resp_core(resp_core), .resp_hit(resp_hit),
    .resp_src(resp_src), .resp_inval(resp_inval), .resp_wb(resp_wb),
    .state0(state0), .state1(state1)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {req_next[1:0], oth_next[1:0], hit, src[1:0], inval, wb}
  function automatic logic [8:0] model(input logic [1:0] r, input logic [1:0] o, input logic w);
    logic [1:0] rn, on, src;
    logic hit, inv, wb;
    hit = (r != 2'b00); rn = r; on = o; src = 2'b00; inv = 1'b0; wb = 1'b0;
    if (!w) begin
      if (r == 2'b00) begin
        rn = 2'b01;
        if (o == 2'b10) begin src = 2'b10; wb = 1'b1; on = 2'b01; end       // R4
        else if (o == 2'b01) src = 2'b10;                                  // R5
        else src = 2'b01;                                                  // R3
      end
    end else begin
      rn = 2'b10; on = 2'b00; inv = (o != 2'b00);                          // R7 R8
      if (r == 2'b00) begin
        src = (o == 2'b00) ? 2'b01 : 2'b10;
        wb  = (o == 2'b10);
      end
    end
    return {rn, on, hit, src, inv, wb};
  endfunction

  function automatic string tag_of(input logic [1:0] r, input logic [1:0] o, input logic w);
    if (w) return (r == 2'b00) ? "R8" : "R7";
    if (r != 2'b00) return "R6";
    if (o == 2'b10) return "R4";
    if (o == 2'b01) return "R5";
    return "R3";
  endfunction

  // Called just after a falling edge; returns after the next falling edge.
  task automatic cyc(input logic v0, input logic w0, input logic v1, input logic w1);
    logic a0, a1, who;
    logic [8:0] e;
    logic [1:0] r, o;
    string t;
    c0_valid = v0; c0_write = w0; c1_valid = v1; c1_write = w1;
    #1;
    chk("R9 c0_ready", {7'd0, c0_ready}, 8'd1);
    chk("R9 c1_ready", {7'd0, c1_ready}, {7'd0, !v0});
    a0 = v0; a1 = v1 && !v0;
    who = a1;
    r = who ? m1 : m0; o = who ? m0 : m1;
    e = model(r, o, who ? w1 : w0);
    t = tag_of(r, o, who ? w1 : w0);
    @(negedge clk);
    if (a0 || a1) begin
      chk("R10 resp_valid", {7'd0, resp_valid}, 8'd1);
      chk("R10 resp_core", {7'd0, resp_core}, {7'd0, who});
      chk({t, " hit/src/inval/wb"}, {3'd0, resp_hit, resp_src, resp_inval, resp_wb}, {3'd0, e[4:0]});
      if (who) begin m1 = e[8:7]; m0 = e[6:5]; end
      else begin m0 = e[8:7]; m1 = e[6:5]; end
    end else begin
      chk("R10 idle resp_valid", {7'd0, resp_valid}, 8'd0);
    end
    chk("R2 joint state", {4'd0, state0, state1}, {4'd0, m0, m1});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; c0_valid = 1'b0; c1_valid = 1'b0;
    #1;
    @(negedge clk);
    chk("R1 ready low in reset", {6'd0, c0_ready, c1_ready}, 8'd0);
    chk("R1 reset state", {4'd0, state0, state1}, 8'd0);
    chk("R1 resp_valid low", {7'd0, resp_valid}, 8'd0);
    rst = 1'b0;
    m0 = 2'b00; m1 = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic p1, pw;
    void'($urandom(32'd5150));
    m0 = 2'b00; m1 = 2'b00;
    do_reset();
    // Directed walk through the transitions
    cyc(1, 0, 0, 0);  // R3 I/I read core0 -> S/I
    cyc(0, 0, 1, 0);  // R5 read core1 from S -> S/S
    cyc(0, 0, 1, 0);  // R6 read hit
    cyc(0, 0, 1, 1);  // R7 S write core1 -> I/M inval
    cyc(1, 0, 0, 0);  // R4 read core0 from M -> S/S wb
    cyc(1, 1, 0, 0);  // R7 write core0 -> M/I inval
    cyc(1, 1, 0, 0);  // R7 M write hit
    cyc(0, 0, 1, 1);  // R8 write miss on dirty peer
    cyc(1, 1, 1, 0);  // R9 both valid: core0 first
    cyc(0, 0, 1, 0);  // R9 held core1 read against new state
    cyc(0, 0, 0, 0);  // R10 idle
    do_reset();
    cyc(0, 0, 1, 1);  // R8 write from I/I -> memory
    cyc(1, 1, 1, 1);  // R9 simultaneous writes
    cyc(0, 0, 1, 1);
    // Random phase, held core1 request kept stable while stalled
    p1 = 1'b0; pw = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      logic v0, w0, v1, w1;
      v0 = ($urandom % 3) == 0;
      w0 = $urandom % 2;
      if (p1) begin v1 = 1'b1; w1 = pw; end
      else begin v1 = ($urandom % 3) == 0; w1 = $urandom % 2; end
      p1 = v1 && v0; pw = w1;
      if (i == 1500) begin do_reset(); p1 = 1'b0; v1 = 1'b0; end
      cyc(v0, w0, v1, w1);
    end
    c0_valid = 1'b0; c1_valid = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule